// File: doc/BRIEF.md
# Dual-Rail Four-Phase Channel Link

This block is a clocked model of a delay-insensitive word channel. A sender takes an N-bit word from a valid/ready port. It puts each bit on its own pair of wires: a "true" rail and a "false" rail. There is no strobe. The receiver watches all the pairs and decides on its own when the word is complete: that is the moment every pair carries a legal data code. Only then does it capture the word and raise a single acknowledge line. The sender answers by taking every pair back to the all-zero spacer. The receiver drops acknowledge once it sees every pair at the spacer again. Only after that can the next word start.

The rails leave the block on one set of ports and come back in on another. Between the two sets, any amount of per-bit wire skew can be placed, and the integrator or the bench decides how much. A pair that shows both rails high is illegal. It sets a sticky error flag, and only reset clears that flag.

Top module: `dr_link`

## Requirements
- R1: While reset is held low, every transmit rail is 0 and `ack`, `out_valid` and `err` are 0. `in_ready` is 1.
- R2: Rail encoding: a bit of value 1 is sent as true=1, false=0, and a bit of value 0 as true=0, false=1. A word accepted on a clock edge is present, encoded, on `tx_true`/`tx_false` right after that edge.
- R3: From the acceptance edge until the link is idle again, `in_ready` stays 0 and the transmit rails do not change until `ack` is seen.
- R4: The receiver captures a word only on an edge where every received pair holds a legal data code (01 or 10). While any pair is still at spacer (00), it neither captures nor acknowledges.
- R5: Each capture produces exactly one cycle of `out_valid`, with `out_data` equal to the true rails as seen at capture. `ack` rises on the same edge.
- R6: One cycle after the sender sees `ack` high, every transmit rail is 0, and the rails stay 0 while `ack` remains high.
- R7: `ack` falls only on an edge where every received pair is at spacer.
- R8: `in_ready` is never 1 while `ack` is 1, so no new word is driven before the spacer phase completes.
- R9: A received pair with both rails high (11) sets `err` on the next edge. `err` then stays 1 until reset.
- R10: Under any per-bit rail skew, words are delivered in the order they were accepted, with none lost and none duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | Sender is idle and can take the offered word |
| in_data | input | W | Word to send |
| tx_true | output | W | Transmit true rails |
| tx_false | output | W | Transmit false rails |
| rx_true | input | W | Received true rails (after wire skew) |
| rx_false | input | W | Received false rails (after wire skew) |
| ack | output | 1 | Receiver acknowledge, also fed to the sender inside the block |
| out_valid | output | 1 | One-cycle pulse: a word was captured |
| out_data | output | W | Captured word |
| err | output | 1 | Sticky illegal-code flag |

## Verification
The bench goes after the ways a receiver can latch early.

- **Partial word.** It holds a single bit's pair at spacer for many cycles while every other bit has already arrived. A receiver that took "no pair changing" or "some pairs valid" as completion would pulse `out_valid` with a partial word.
- **Skewed return to spacer.** Random per-bit skew is applied to both the data phase and the spacer phase. A receiver that drops `ack` on the first null pair, instead of the last, would let the next word overlap the tail of the previous one. That shows up as a wrong or duplicated word in the in-order scoreboard.
- **Illegal code.** An injected 11 code checks that `err` both sets and stays set. A flag that is not sticky would be missed as soon as the pair recovers.

// File: rtl/dr_pkg.sv
// Shared types for the dual-rail link.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dr_pkg;

    // Sender phase.
    typedef enum logic [1:0] {
        SND_IDLE   = 2'd0,
        SND_DRIVE  = 2'd1,
        SND_RETURN = 2'd2
    } snd_state_t;

    // Receiver phase: free to capture, or holding an acknowledged word.
    typedef enum logic {
        RCV_FREE = 1'b0,
        RCV_HELD = 1'b1
    } rcv_state_t;

endpackage

// File: rtl/dr_detect.sv
// Completion detector over W dual-rail pairs.
// Classifies each pair as spacer (00), data (01/10) or illegal (11).
// It then reduces the per-pair results to whole-word flags.
// Assumes: the inputs are already in the clock domain. Purely combinational.
module dr_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] rail_t,
    input  logic [W-1:0] rail_f,
    output logic         all_data,
    output logic         all_spacer,
    output logic         any_bad
);
    logic [W-1:0] pair_data;
    logic [W-1:0] pair_spacer;
    logic [W-1:0] pair_bad;

    // Per-pair code classification.
    for (genvar i = 0; i < W; i++) begin : g_pair
        assign pair_data[i]   = rail_t[i] ^ rail_f[i];
        assign pair_spacer[i] = ~(rail_t[i] | rail_f[i]);
        assign pair_bad[i]    = rail_t[i] & rail_f[i];
    end

    // Word-level reduction.
    always_comb begin
        all_data   = &pair_data;
        all_spacer = &pair_spacer;
        any_bad    = |pair_bad;
    end
endmodule

// File: rtl/dr_sender.sv
// Dual-rail four-phase sender.
// Takes a word from a valid/ready port and drives it encoded on the rails.
// When ack is seen, it returns all rails to spacer, then waits for ack to fall.
// Assumes: ack_i is synchronous to clk.
module dr_sender
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         ack_i,
    output logic [W-1:0] tx_t,
    output logic [W-1:0] tx_f
);
    snd_state_t state;

    // Ready only when idle and the previous handshake has fully closed.
    always_comb in_ready = (state == SND_IDLE) && !ack_i;

    // Phase sequencing and rail registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SND_IDLE;
            tx_t  <= '0;
            tx_f  <= '0;
        end else begin
            case (state)
                SND_IDLE: begin
                    if (in_valid && !ack_i) begin
                        tx_t  <= in_data;
                        tx_f  <= ~in_data;
                        state <= SND_DRIVE;
                    end
                end
                SND_DRIVE: begin
                    if (ack_i) begin
                        tx_t  <= '0;
                        tx_f  <= '0;
                        state <= SND_RETURN;
                    end
                end
                SND_RETURN: begin
                    if (!ack_i) state <= SND_IDLE;
                end
                default: state <= SND_IDLE;
            endcase
        end
    end

    // Accepted word appears encoded on the rails next cycle.
    p_accept_encode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (tx_t == $past(in_data) && tx_f == ~$past(in_data)));
    // Rails stay put while waiting for ack.
    p_drive_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SND_DRIVE && !ack_i) |=> ($stable(tx_t) && $stable(tx_f)));
    // After ack is seen, all rails are spacer.
    p_spacer_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SND_IDLE && ack_i) |=> (tx_t == '0 && tx_f == '0));
endmodule

// File: rtl/dr_receiver.sv
// Dual-rail four-phase receiver.
// Captures a word once completion shows every pair holding data, then raises ack.
// It drops ack after every pair has returned to spacer. Flags illegal codes stickily.
// Assumes: rails are stable within a clock period (the skew is in whole cycles).
module dr_receiver
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx_t,
    input  logic [W-1:0] rx_f,
    output logic         ack,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         err
);
    rcv_state_t state;
    logic       all_data;
    logic       all_spacer;
    logic       any_bad;

    dr_detect #(.W(W)) u_detect (
        .rail_t     (rx_t),
        .rail_f     (rx_f),
        .all_data   (all_data),
        .all_spacer (all_spacer),
        .any_bad    (any_bad)
    );

    // Capture, acknowledge and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RCV_FREE;
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                RCV_FREE: begin
                    if (all_data) begin
                        out_data  <= rx_t;
                        out_valid <= 1'b1;
                        ack       <= 1'b1;
                        state     <= RCV_HELD;
                    end
                end
                RCV_HELD: begin
                    if (all_spacer) begin
                        ack   <= 1'b0;
                        state <= RCV_FREE;
                    end
                end
                default: state <= RCV_FREE;
            endcase
        end
    end

    // Sticky illegal-code flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (any_bad) err <= 1'b1;
    end

    // Acknowledge rises only after a complete word.
    p_capture_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(all_data));
    // Output valid is a single-cycle pulse.
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // Acknowledge falls only after a full spacer.
    p_release_spacer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> $past(all_spacer));
    // Error flag never clears outside reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/dr_link.sv
// Dual-rail four-phase channel link: sender plus receiver.
// Rails leave on tx_* and return on rx_*, so that external wiring or skew can sit between them.
// Acknowledge is routed inside the block and is also visible on the ack port.
// Assumes: rx_* is a (possibly skewed) copy of tx_*, synchronous to clk.
module dr_link #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] tx_true,
    output logic [W-1:0] tx_false,
    input  logic [W-1:0] rx_true,
    input  logic [W-1:0] rx_false,
    output logic         ack,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         err
);
    dr_sender #(.W(W)) u_snd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .ack_i    (ack),
        .tx_t     (tx_true),
        .tx_f     (tx_false)
    );

    dr_receiver #(.W(W)) u_rcv (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_t      (rx_true),
        .rx_f      (rx_false),
        .ack       (ack),
        .out_valid (out_valid),
        .out_data  (out_data),
        .err       (err)
    );

    // Ready and acknowledge are never high together.
    p_no_ready_during_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && ack));
endmodule

// File: tb/dr_link_test.sv
`timescale 1ns/1ps
// Bench for dr_link.
// Applies random per-bit skew (0..3 cycles) to every rail-pair transition.
// Uses a scoreboard for ordering, plus directed holdback and illegal-code cases.
module dr_link_test;
    localparam int W = 8;
    localparam int NWORDS = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] tx_true, tx_false;
    logic [W-1:0] rx_true = '0, rx_false = '0;
    logic         ack, out_valid, err;
    logic [W-1:0] out_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [W-1:0] exp_q [0:255];
    int wr = 0, rd = 0;

    logic [W-1:0] hold = '0;
    bit inj = 0;
    int inj_bit = 0;
    int cnt [W];
    bit prev_ack = 0, prev_ov = 0;

    dr_link #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .tx_true(tx_true), .tx_false(tx_false),
        .rx_true(rx_true), .rx_false(rx_false), .ack(ack),
        .out_valid(out_valid), .out_data(out_data), .err(err)
    );

    always #5 clk = ~clk;

    function automatic bit all_spacer(logic [W-1:0] t, logic [W-1:0] f);
        return (t == '0) && (f == '0);
    endfunction

    function automatic bit all_data(logic [W-1:0] t, logic [W-1:0] f);
        return (t ^ f) == '1;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor (reads the values the last edge saw), then the skewed rail update.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                // R4: complete, legal word on the rails at capture
                check(all_data(rx_true, rx_false) && rx_true == out_data,
                      "R4", {24'd0, rx_true}, {24'd0, out_data});
                // R5: single pulse with ack
                check(!prev_ov && ack, "R5", {30'd0, prev_ov, ack}, 32'd1);
                // R10: in-order, nothing extra
                if (rd < wr) begin
                    check(out_data == exp_q[rd[7:0]], "R10", {24'd0, out_data}, {24'd0, exp_q[rd[7:0]]});
                    rd++;
                end else begin
                    check(0, "R10 extra word", {24'd0, out_data}, 32'd0);
                end
            end
            if (prev_ack && !ack)  // R7
                check(all_spacer(rx_true, rx_false), "R7", {24'd0, rx_true | rx_false}, 32'd0);
            if (prev_ack)          // R6
                check(all_spacer(tx_true, tx_false), "R6", {24'd0, tx_true | tx_false}, 32'd0);
            if (ack)               // R8
                check(!in_ready, "R8", {31'd0, in_ready}, 32'd0);
            prev_ack = ack;
            prev_ov  = out_valid;
        end
        for (int i = 0; i < W; i++) begin
            if (!rst_n) begin
                rx_true[i] = 1'b0; rx_false[i] = 1'b0; cnt[i] = 0;
            end else if (hold[i]) begin
                // bit frozen by the bench
            end else if (inj && i == inj_bit) begin
                rx_true[i] = 1'b1; rx_false[i] = 1'b1;
            end else if ({rx_true[i], rx_false[i]} != {tx_true[i], tx_false[i]}) begin
                if (cnt[i] == 0) begin
                    rx_true[i]  = tx_true[i];
                    rx_false[i] = tx_false[i];
                    cnt[i] = int'($urandom % 4);
                end else begin
                    cnt[i]--;
                end
            end
        end
    end

    // Offer one word, wait for acceptance, check encoding and stall.
    task automatic send(logic [W-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        exp_q[wr[7:0]] = w;
        wr++;
        @(posedge clk);
        #1;
        check(tx_true == w && tx_false == ~w, "R2", {8'd0, tx_true, 8'd0, tx_false}, {8'd0, w, 8'd0, ~w});
        check(!in_ready, "R3", {31'd0, in_ready}, 32'd0);
        in_valid = 1'b0;
        in_data  = $urandom;
    endtask

    task automatic wait_drain();
        int n = 0;
        while ((rd < wr || !in_ready) && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(tx_true == '0 && tx_false == '0, "R1 rails", {24'd0, tx_true | tx_false}, 32'd0);
        check(!ack && !out_valid && !err, "R1 flags", {29'd0, ack, out_valid, err}, 32'd0);
        check(in_ready, "R1 ready", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed extremes
        send('0);
        send('1);
        send(8'hA5);

        // R3: word held off while a transfer is open; the offered data changes meanwhile
        wait_drain();

        // R4: one bit held at spacer while the others arrive
        hold[3] = 1'b1;
        send(8'h5A);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(!out_valid && !ack, "R4 holdback", {30'd0, out_valid, ack}, 32'd0);
        end
        hold[3] = 1'b0;
        wait_drain();
        check(rd == wr, "R4 release", rd, wr);

        // R10: random traffic with gaps
        for (int k = 0; k < NWORDS; k++) begin
            send(W'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end
        wait_drain();
        check(rd == wr, "R10 count", rd, wr);

        // R9: illegal 11 code
        check(!err, "R9 clean", {31'd0, err}, 32'd0);
        @(negedge clk);
        inj_bit = 2;
        inj = 1;
        @(negedge clk);
        @(negedge clk);
        check(err, "R9 set", {31'd0, err}, 32'd1);
        inj = 0;
        repeat (10) @(negedge clk);
        check(err, "R9 sticky", {31'd0, err}, 32'd1);
        finish_up();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end
endmodule